// File: doc/BRIEF.md
# Cascadable Segment Line Loader

This block collects one display line of pixel bits for a column driver that shares a parallel data bus with further drivers of the same kind, chained one after another. Pixel data arrive on a shift strobe as 4-bit nibbles or 8-bit bytes. They are packed into bytes and written into a capture bank. A write pointer walks the bank in groups of `GROUP_BITS` bits. The fill runs from the lowest group up or from the highest group down.

Each chip becomes active when its active-low enable input is seen low while it is armed. It then counts bytes by itself. After exactly `LINE_BITS` bits it drives its active-low cascade output low, so the next chip on the chain takes over the bus. From then on it ignores the strobe. Which of the two enable pins acts as the input and which as the output follows the fill direction. On the falling edge of the line pulse the whole captured line is copied into the output line latch, and the loader is armed again. An active-low blanking input clears the line latch.

Top module: `seg_line_loader`

## Requirements
- R1: With `wide_mode`=1, each accepted strobe delivers one byte from `pix_in[7:0]`, and bit i of that byte lands at bit 8·s+i of the line, where s is the byte's slot.
- R2: With `wide_mode`=0, two accepted strobes make one byte. Only `pix_in[3:0]` is used. The first nibble becomes bits 7..4 of the byte and the second nibble becomes bits 3..0.
- R3: The k-th byte of a line (k counted from 0) goes to slot k when `dir_rev`=0 and to slot `LINE_BITS`/8−1−k when `dir_rev`=1. The group pointer therefore moves one group for every `GROUP_BITS`/8 bytes.
- R4: While armed, strobes are ignored until the enable input is seen low on the same cycle as a strobe. That strobe is accepted, and the chip then stays selected without the enable. The enable input is `eio_l_in_n` when `dir_rev`=0 and `eio_r_in_n` when `dir_rev`=1. The other pin is ignored.
- R5: The cascade output is `eio_r_out_n` when `dir_rev`=0 and `eio_l_out_n` when `dir_rev`=1. It goes low in the cycle after the `LINE_BITS`/8-th byte completes. It stays low until the next line-pulse falling edge. The pin that is not the output stays high.
- R6: Once the line is complete, further strobes change nothing that the next transfer would show.
- R7: A falling edge of `line_pulse` is a cycle where it is sampled 0 after being sampled 1. On the clock of that cycle the captured line is copied into `line_out`, and the loader is re-armed. A strobe in that same cycle is dropped. At all other times `line_out` holds its value.
- R8: While `disp_off_n` is 0, `line_out` is cleared on the next clock. This takes priority over a transfer. The capture bank is not affected.
- R9: A nibble still waiting for its partner at a line-pulse falling edge is discarded. The next line starts with a fresh upper nibble.
- R10: After reset `line_out` is all zero, both cascade pins are high, and the loader is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_stb | input | 1 | One-cycle strobe: `pix_in` holds valid data |
| pix_in | input | 8 | Pixel data (bits 3..0 only in nibble mode) |
| wide_mode | input | 1 | 1 = byte per strobe, 0 = nibble per strobe |
| dir_rev | input | 1 | 0 = fill from slot 0 up, 1 = from the last slot down |
| line_pulse | input | 1 | Line pulse; its falling edge transfers the line |
| disp_off_n | input | 1 | Active-low blanking of the line latch |
| eio_l_in_n | input | 1 | Left enable pin, input side |
| eio_r_in_n | input | 1 | Right enable pin, input side |
| eio_l_out_n | output | 1 | Left enable pin, output side |
| eio_r_out_n | output | 1 | Right enable pin, output side |
| line_out | output | LINE_BITS | Latched display line |

## Verification
The bench builds the loader with `LINE_BITS`=48 and `GROUP_BITS`=16, which gives six bytes in three groups. A full line then takes a few dozen cycles. This makes it cheap to sweep every combination of width mode and fill direction over several data patterns, and to check the cascade hand-off at the exact byte count each time. The small line also keeps room for the directed cases: wrong-side enables, enable released after selection, a half byte cut off by the line pulse, strobes after completion, and blanking during a transfer.

// File: rtl/seg_loader_pkg.sv
// Package: shared constants and the loader state type.
// Assumes byte-wide internal data; the nibble width is half a byte.
package seg_loader_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    // Loader state: waiting for enable, taking data, or finished for this line.
    typedef enum logic [1:0] {
        LD_ARMED = 2'd0,
        LD_SEL   = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/seg_nibble_packer.sv
// Module: seg_nibble_packer
// Turns accepted strobes into bytes. In byte mode every accepted strobe is
// a byte. In nibble mode the first nibble is held as the upper half and the
// second completes the byte. Assumes 'take' is already qualified by selection.
// 'flush' drops a pending half byte.
module seg_nibble_packer
    import seg_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              take,
    input  logic              wide,
    input  logic [BYTE_W-1:0] din,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out
);

    logic             half_q;
    logic [NIB_W-1:0] hi_q;

    // Nibble phase and held upper nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            hi_q   <= '0;
        end else if (flush) begin
            half_q <= 1'b0;
        end else if (take && wide) begin
            half_q <= 1'b0;
        end else if (take) begin
            half_q <= ~half_q;
            if (!half_q) begin
                hi_q <= din[NIB_W-1:0];
            end
        end
    end

    // Byte completion and assembled value.
    always_comb begin
        byte_vld = take && (wide || half_q);
        byte_out = wide ? din : {hi_q, din[NIB_W-1:0]};
    end

endmodule

// File: rtl/seg_sel_control.sv
// Module: seg_sel_control
// Selection state, byte counter and write pointer. The loader arms on
// 'rearm' (the line-pulse falling edge). It becomes selected on a strobe
// seen with the enable low, counts completed bytes, and finishes after
// LINE_BYTES bytes. The slot of the current byte follows the fill
// direction and is split into a one-hot group select and a byte-in-group
// index. Assumes LINE_BYTES is a multiple of GROUP_BYTES.
module seg_sel_control
    import seg_loader_pkg::*;
#(
    parameter int LINE_BYTES  = 30,
    parameter int GROUP_BYTES = 2,
    parameter int NGROUPS     = 15,
    parameter int CNT_W       = 5,
    parameter int BSEL_W      = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rearm,
    input  logic               stb,
    input  logic               en_in_n,
    input  logic               dir_rev,
    input  logic               byte_vld,
    output logic               take,
    output logic               done,
    output logic [NGROUPS-1:0] grp_sel,
    output logic [BSEL_W-1:0]  bsel
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_BYTES - 1);

    ld_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot;
    int unsigned      slot_i;

    // Strobe acceptance: selected, or armed with the enable seen now.
    always_comb begin
        take = stb && !rearm &&
               ((state_q == LD_SEL) || ((state_q == LD_ARMED) && !en_in_n));
        done = (state_q == LD_DONE);
    end

    // Selection state and byte count for the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_ARMED;
            cnt_q   <= '0;
        end else if (rearm) begin
            state_q <= LD_ARMED;
            cnt_q   <= '0;
        end else if (take) begin
            if (state_q == LD_ARMED) begin
                state_q <= LD_SEL;
            end
            if (byte_vld) begin
                if (cnt_q == LAST) begin
                    state_q <= LD_DONE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Slot of the current byte, split into group and byte position.
    always_comb begin
        slot    = dir_rev ? (LAST - cnt_q) : cnt_q;
        slot_i  = int'(slot);
        bsel    = BSEL_W'(slot_i % GROUP_BYTES);
        grp_sel = '0;
        for (int g = 0; g < NGROUPS; g++) begin
            grp_sel[g] = take && ((slot_i / GROUP_BYTES) == g);
        end
    end

endmodule

// File: rtl/seg_capture_bank.sv
// Module: seg_capture_bank
// Capture storage, one register set per latch group. A completed byte is
// written into the group picked by the one-hot select, at the byte position
// 'bsel'. Slot s occupies bits 8*s+7..8*s of the flat output. The contents
// survive line pulses and are only overwritten by new data.
module seg_capture_bank
    import seg_loader_pkg::*;
#(
    parameter int NGROUPS     = 15,
    parameter int GROUP_BYTES = 2,
    parameter int BSEL_W      = 1,
    parameter int LINE_BITS   = NGROUPS * GROUP_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [NGROUPS-1:0]   grp_sel,
    input  logic [BSEL_W-1:0]    bsel,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [LINE_BITS-1:0] cap
);

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        logic [GROUP_BYTES-1:0][BYTE_W-1:0] grp_q;

        // Byte writes into this group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_q <= '0;
            end else if (wr && grp_sel[g]) begin
                for (int b = 0; b < GROUP_BYTES; b++) begin
                    if (bsel == BSEL_W'(b)) begin
                        grp_q[b] <= wdata;
                    end
                end
            end
        end

        assign cap[g*GROUP_BYTES*BYTE_W +: GROUP_BYTES*BYTE_W] = grp_q;
    end

endmodule

// File: rtl/seg_line_latch.sv
// Module: seg_line_latch
// Output line register. It loads the whole captured line at once on 'load'.
// Blanking clears it and takes priority over a load.
module seg_line_latch #(
    parameter int W = 240
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blank_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Line hold with clear and parallel load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (!blank_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/seg_line_loader.sv
// Module: seg_line_loader (top)
// Cascadable line loader for a segment column driver. It detects the
// falling edge of the line pulse, routes the enable pins by fill direction
// and wires the packer, the selection control, the capture bank and the
// line latch together. Assumes LINE_BITS is a multiple of GROUP_BITS and
// GROUP_BITS is a multiple of 8. All inputs are synchronous to clk.
module seg_line_loader
    import seg_loader_pkg::*;
#(
    parameter int LINE_BITS  = 240,
    parameter int GROUP_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_stb,
    input  logic [7:0]           pix_in,
    input  logic                 wide_mode,
    input  logic                 dir_rev,
    input  logic                 line_pulse,
    input  logic                 disp_off_n,
    input  logic                 eio_l_in_n,
    input  logic                 eio_r_in_n,
    output logic                 eio_l_out_n,
    output logic                 eio_r_out_n,
    output logic [LINE_BITS-1:0] line_out
);

    localparam int LINE_BYTES  = LINE_BITS / BYTE_W;
    localparam int GROUP_BYTES = GROUP_BITS / BYTE_W;
    localparam int NGROUPS     = LINE_BITS / GROUP_BITS;
    localparam int CNT_W       = $clog2(LINE_BYTES + 1);
    localparam int BSEL_W      = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1;

    logic                 lp_q;
    logic                 lp_fall;
    logic                 en_in_n;
    logic                 take;
    logic                 done;
    logic                 byte_vld;
    logic [BYTE_W-1:0]    byte_val;
    logic [NGROUPS-1:0]   grp_sel;
    logic [BSEL_W-1:0]    bsel;
    logic [LINE_BITS-1:0] cap;

    // Line-pulse history for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q <= 1'b0;
        end else begin
            lp_q <= line_pulse;
        end
    end

    // Edge detect and enable-pin routing by fill direction.
    always_comb begin
        lp_fall     = lp_q && !line_pulse;
        en_in_n     = dir_rev ? eio_r_in_n : eio_l_in_n;
        eio_r_out_n = dir_rev ? 1'b1 : !done;
        eio_l_out_n = dir_rev ? !done : 1'b1;
    end

    seg_nibble_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (lp_fall),
        .take     (take),
        .wide     (wide_mode),
        .din      (pix_in),
        .byte_vld (byte_vld),
        .byte_out (byte_val)
    );

    seg_sel_control #(
        .LINE_BYTES  (LINE_BYTES),
        .GROUP_BYTES (GROUP_BYTES),
        .NGROUPS     (NGROUPS),
        .CNT_W       (CNT_W),
        .BSEL_W      (BSEL_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rearm    (lp_fall),
        .stb      (shift_stb),
        .en_in_n  (en_in_n),
        .dir_rev  (dir_rev),
        .byte_vld (byte_vld),
        .take     (take),
        .done     (done),
        .grp_sel  (grp_sel),
        .bsel     (bsel)
    );

    seg_capture_bank #(
        .NGROUPS     (NGROUPS),
        .GROUP_BYTES (GROUP_BYTES),
        .BSEL_W      (BSEL_W),
        .LINE_BITS   (LINE_BITS)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (byte_vld),
        .grp_sel (grp_sel),
        .bsel    (bsel),
        .wdata   (byte_val),
        .cap     (cap)
    );

    seg_line_latch #(
        .W (LINE_BITS)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank_n (disp_off_n),
        .load    (lp_fall),
        .din     (cap),
        .dout    (line_out)
    );

endmodule

// Module: seg_line_loader_chk
// Property checker bound into every seg_line_loader instance.
module seg_line_loader_chk #(
    parameter int LINE_BITS = 240,
    parameter int NGROUPS   = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 disp_off_n,
    input logic                 dir_rev,
    input logic                 lp_fall,
    input logic                 done,
    input logic                 byte_vld,
    input logic                 eio_l_out_n,
    input logic                 eio_r_out_n,
    input logic [NGROUPS-1:0]   grp_sel,
    input logic [LINE_BITS-1:0] line_out
);

    assert_grp_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_sel));

    assert_cas_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lp_fall) |=> done);

    assert_idle_side_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rev ? eio_r_out_n : eio_l_out_n);

    assert_no_write_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !byte_vld);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_fall && disp_off_n) |=> $stable(line_out));

    assert_blank_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_off_n |=> (line_out == '0));

endmodule

bind seg_line_loader seg_line_loader_chk #(
    .LINE_BITS (LINE_BITS),
    .NGROUPS   (NGROUPS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_off_n  (disp_off_n),
    .dir_rev     (dir_rev),
    .lp_fall     (lp_fall),
    .done        (done),
    .byte_vld    (byte_vld),
    .eio_l_out_n (eio_l_out_n),
    .eio_r_out_n (eio_r_out_n),
    .grp_sel     (grp_sel),
    .line_out    (line_out)
);

// File: tb/sim_seg_line_loader.sv
// Bench for seg_line_loader built with a 48-bit line in 16-bit groups.
module sim_seg_line_loader;

    localparam int LB = 48;
    localparam int GB = 16;
    localparam int NB = LB / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_stb = 1'b0;
    logic [7:0]    pix_in = '0;
    logic          wide_mode = 1'b1;
    logic          dir_rev = 1'b0;
    logic          line_pulse = 1'b0;
    logic          disp_off_n = 1'b1;
    logic          eio_l_in_n = 1'b1;
    logic          eio_r_in_n = 1'b1;
    logic          eio_l_out_n;
    logic          eio_r_out_n;
    logic [LB-1:0] line_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seg_line_loader #(.LINE_BITS(LB), .GROUP_BITS(GB)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_stb   (shift_stb),
        .pix_in      (pix_in),
        .wide_mode   (wide_mode),
        .dir_rev     (dir_rev),
        .line_pulse  (line_pulse),
        .disp_off_n  (disp_off_n),
        .eio_l_in_n  (eio_l_in_n),
        .eio_r_in_n  (eio_r_in_n),
        .eio_l_out_n (eio_l_out_n),
        .eio_r_out_n (eio_r_out_n),
        .line_out    (line_out)
    );

    function automatic logic [7:0] pat(int n, int k);
        return 8'((n * 53 + k * 29 + 7) ^ (k * 16));
    endfunction

    function automatic logic [LB-1:0] line_of(int n, bit dir);
        logic [LB-1:0] r = '0;
        for (int k = 0; k < NB; k++) begin
            int s = dir ? (NB - 1 - k) : k;
            r[s*8 +: 8] = pat(n, k);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] v);
        @(negedge clk);
        shift_stb = 1'b1;
        pix_in = v;
        @(negedge clk);
        shift_stb = 1'b0;
        pix_in = '0;
    endtask

    // Upper input bits carry junk in nibble mode (R2).
    task automatic put_byte(input logic [7:0] b);
        if (wide_mode) begin
            strobe(b);
        end else begin
            strobe({4'hF, b[7:4]});
            strobe({4'hA, b[3:0]});
        end
    endtask

    task automatic pulse_line();
        @(negedge clk);
        line_pulse = 1'b1;
        @(negedge clk);
        line_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_side(input bit dir, input bit en_low);
        dir_rev = dir;
        eio_l_in_n = dir ? 1'b1 : !en_low;
        eio_r_in_n = dir ? !en_low : 1'b1;
    endtask

    function automatic logic out_pin();
        return dir_rev ? eio_l_out_n : eio_r_out_n;
    endfunction

    function automatic logic idle_pin();
        return dir_rev ? eio_r_out_n : eio_l_out_n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [LB-1:0] prev;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset line", line_out, '0);
        chk("R10 reset pins", {46'd0, eio_l_out_n, eio_r_out_n}, 48'd3);

        // Sweep: both width modes, both directions, four patterns each.
        n = 0;
        for (int w = 0; w < 2; w++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 4; p++) begin
                    wide_mode = w[0];
                    set_side(d[0], 1'b1);
                    for (int k = 0; k < NB - 1; k++) put_byte(pat(n, k));
                    chk("R5 not yet done", {47'd0, out_pin()}, 48'd1);
                    put_byte(pat(n, NB - 1));
                    chk("R5 cascade low", {47'd0, out_pin()}, 48'd0);
                    chk("R5 idle side high", {47'd0, idle_pin()}, 48'd1);
                    put_byte(8'h5A);
                    put_byte(8'hC3);
                    chk("R5 held low", {47'd0, out_pin()}, 48'd0);
                    pulse_line();
                    chk(w ? (d ? "R1 R3 R6 byte rev" : "R1 R6 byte fwd")
                          : (d ? "R2 R3 R6 nibble rev" : "R2 R6 nibble fwd"),
                        line_out, line_of(n, d[0]));
                    chk("R5 released", {47'd0, out_pin()}, 48'd1);
                    n++;
                end
            end
        end

        // R4: wrong-side enable ignored, then enable for one strobe only.
        wide_mode = 1'b1;
        dir_rev = 1'b0;
        eio_l_in_n = 1'b1;
        eio_r_in_n = 1'b0;
        for (int k = 0; k < NB; k++) put_byte(8'hEE);
        chk("R4 wrong side ignored", {47'd0, eio_r_out_n}, 48'd1);
        eio_r_in_n = 1'b1;
        eio_l_in_n = 1'b0;
        put_byte(pat(n, 0));
        eio_l_in_n = 1'b1;
        for (int k = 1; k < NB; k++) put_byte(pat(n, k));
        chk("R4 stays selected", {47'd0, eio_r_out_n}, 48'd0);
        prev = line_out;
        @(negedge clk);
        line_pulse = 1'b1;
        @(negedge clk);
        chk("R7 hold while pulse high", line_out, prev);
        line_pulse = 1'b0;
        @(negedge clk);
        chk("R4 R7 transferred", line_out, line_of(n, 1'b0));
        n++;

        // R9: half byte cut off by the line pulse.
        wide_mode = 1'b0;
        set_side(1'b1, 1'b1);
        strobe(8'h07);
        pulse_line();
        for (int k = 0; k < NB; k++) put_byte(pat(n, k));
        chk("R9 count after drop", {47'd0, eio_l_out_n}, 48'd0);
        pulse_line();
        chk("R9 fresh nibble phase", line_out, line_of(n, 1'b1));
        prev = line_out;
        n++;

        // R8: blanking clears and beats a transfer; capture survives.
        wide_mode = 1'b1;
        set_side(1'b0, 1'b1);
        for (int k = 0; k < NB; k++) put_byte(pat(n, k));
        @(negedge clk);
        disp_off_n = 1'b0;
        @(negedge clk);
        chk("R8 clear", line_out, '0);
        pulse_line();
        chk("R8 priority over transfer", line_out, '0);
        disp_off_n = 1'b1;
        @(negedge clk);
        chk("R8 stays clear", line_out, '0);
        pulse_line();
        chk("R7 R8 capture kept", line_out, line_of(n, 1'b0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule